// File: doc/BRIEF.md
# Column-Compression Unsigned Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product, with no clock and no state. It builds one AND term for every pair of operand bits, places each term in the column of its binary weight, and then squeezes the columns layer by layer. In each layer, full adders take three wires of a column at a time, and a half adder takes a leftover pair. When no column holds more than two wires, the survivors form two rows, and a two-operand adder sums them.

The number of layers, the wire count of every column in every layer and the position of each wire are worked out at elaboration from N alone. Changing N therefore reshapes the whole tree. A parameter picks how the final two rows are added: with a behavioural adder, or with a ripple chain of the same explicit full-adder cells that the tree uses. The block sits inside a larger datapath, which registers its inputs and outputs as that datapath's timing requires.

Top module: `wt_mult`

## Requirements
- R1: For every pair of N-bit operands, `prod` equals op_a × op_b as an exact 2N-bit unsigned value, with bit 0 as the least significant bit. The default is N=8.
- R2: When either operand is zero, `prod` is zero.
- R3: When one operand equals 1, `prod` equals the other operand zero-extended to 2N bits.
- R4: When both operands are all ones, `prod` equals (2^N−1)², so both bit 2N−1 and bit 0 are set. A carry that reaches the top column is kept.
- R5: When one operand has a single bit set at position k, `prod` equals the other operand shifted left by k.
- R6: `prod[0]` always equals op_a[0] AND op_b[0].
- R7: With N=4 and FINAL_ADDER=1, the final addition uses a ripple chain of full-adder cells, and the result is exact for all 256 operand pairs. FINAL_ADDER=0 selects a behavioural adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product, full width |

## Verification
With all-ones operands, two things must come out right together. The carries that climb out of the compression layers land in the uppermost column, and the final adder propagates a carry through almost every bit position. The all-ones corner at N=8, and the 15×15 case within the exhaustive N=4 sweep, create this overlap. They are judged against the exact square computed in the bench, including the top bit. The random sweep pairs the R1 product check with the bit-0 check of R6 on the same input vector, so the weight-one column and the deepest columns are checked together.

// File: rtl/wt_pkg.sv
package wt_pkg;

   localparam int MAX_COLS = 128;

   // outputs that stay in a column of height h (sums, half-adder sum, pass wire)
   function automatic int own_out(int h);
      return h / 3 + (((h % 3) != 0) ? 1 : 0);
   endfunction

   // carries that a column of height h sends one column up
   function automatic int car_out(int h);
      return h / 3 + (((h % 3) == 2) ? 1 : 0);
   endfunction

   function automatic int pp_lo(int n, int c);
      return (c > n - 1) ? c - n + 1 : 0;
   endfunction

   function automatic int pp_hi(int n, int c);
      return (c < n - 1) ? c : n - 1;
   endfunction

   // wire count of column c entering layer l (layer 0 = raw partial products)
   function automatic int col_h(int n, int l, int c);
      int h [MAX_COLS];
      int t [MAX_COLS];
      for (int k = 0; k < MAX_COLS; k++) begin
         h[k] = 0;
         t[k] = 0;
      end
      for (int k = 0; k < 2 * n - 1; k++)
         h[k] = pp_hi(n, k) - pp_lo(n, k) + 1;
      for (int s = 0; s < l; s++) begin
         for (int k = 0; k < 2 * n; k++)
            t[k] = own_out(h[k]) + ((k > 0) ? car_out(h[k-1]) : 0);
         for (int k = 0; k < 2 * n; k++)
            h[k] = t[k];
      end
      if (c < 0 || c >= 2 * n)
         return 0;
      return h[c];
   endfunction

   function automatic int col_off(int n, int l, int c);
      int acc;
      acc = 0;
      for (int k = 0; k < c; k++)
         acc += col_h(n, l, k);
      return acc;
   endfunction

   function automatic int layer_tot(int n, int l);
      return col_off(n, l, 2 * n);
   endfunction

   function automatic int max_h(int n, int l);
      int m;
      m = 0;
      for (int k = 0; k < 2 * n; k++)
         if (col_h(n, l, k) > m)
            m = col_h(n, l, k);
      return m;
   endfunction

   function automatic int num_layers(int n);
      int l;
      l = 0;
      while (max_h(n, l) > 2 && l < 40)
         l++;
      return l;
   endfunction

endpackage

// File: rtl/wt_cells.sv
module wt_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   assign s  = a ^ b ^ ci;
   assign co = (a & b) | (ci & (a ^ b));
endmodule

module wt_ha (
   input  logic a,
   input  logic b,
   output logic s,
   output logic co
);
   assign s  = a ^ b;
   assign co = a & b;
endmodule

// File: rtl/wt_ppgen.sv
module wt_ppgen
   import wt_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]                op_a,
   input  logic [N-1:0]                op_b,
   output logic [layer_tot(N, 0)-1:0]  pp
);
   localparam int W = 2 * N;

   for (genvar c = 0; c < W - 1; c++) begin : g_col
      localparam int LO  = pp_lo(N, c);
      localparam int HI  = pp_hi(N, c);
      localparam int OFF = col_off(N, 0, c);
      for (genvar i = LO; i <= HI; i++) begin : g_bit
         assign pp[OFF + i - LO] = op_a[i] & op_b[c - i];
      end
   end
endmodule

// File: rtl/wt_layer.sv
module wt_layer
   import wt_pkg::*;
#(
   parameter int N = 8,
   parameter int L = 0
) (
   input  logic [layer_tot(N, L)-1:0]    din,
   output logic [layer_tot(N, L+1)-1:0]  dout
);
   localparam int W = 2 * N;

   for (genvar c = 0; c < W; c++) begin : g_col
      localparam int H   = col_h(N, L, c);
      localparam int NF  = H / 3;
      localparam int REM = H % 3;
      localparam int IB  = col_off(N, L, c);
      localparam int OB  = col_off(N, L + 1, c);
      localparam bit TOP = (c == W - 1);
      localparam int CN  = TOP ? 0 : col_off(N, L + 1, c + 1) + own_out(col_h(N, L, c + 1));

      for (genvar k = 0; k < NF; k++) begin : g_fa
         if (TOP) begin : g_sum_only
            assign dout[OB + k] = din[IB + 3*k] ^ din[IB + 3*k + 1] ^ din[IB + 3*k + 2];
         end else begin : g_cell
            wt_fa u_fa (
               .a  (din[IB + 3*k]),
               .b  (din[IB + 3*k + 1]),
               .ci (din[IB + 3*k + 2]),
               .s  (dout[OB + k]),
               .co (dout[CN + k])
            );
         end
      end

      if (REM == 2) begin : g_half
         if (TOP) begin : g_sum_only
            assign dout[OB + NF] = din[IB + 3*NF] ^ din[IB + 3*NF + 1];
         end else begin : g_cell
            wt_ha u_ha (
               .a  (din[IB + 3*NF]),
               .b  (din[IB + 3*NF + 1]),
               .s  (dout[OB + NF]),
               .co (dout[CN + NF])
            );
         end
      end else if (REM == 1) begin : g_pass
         assign dout[OB + NF] = din[IB + 3*NF];
      end
   end
endmodule

// File: rtl/wt_final.sv
module wt_final
   import wt_pkg::*;
#(
   parameter int N           = 8,
   parameter int L           = 0,
   parameter int FINAL_ADDER = 0
) (
   input  logic [layer_tot(N, L)-1:0]  din,
   output logic [2*N-1:0]              prod
);
   localparam int W = 2 * N;

   logic [W-1:0] row0;
   logic [W-1:0] row1;

   for (genvar c = 0; c < W; c++) begin : g_col
      localparam int H   = col_h(N, L, c);
      localparam int OFF = col_off(N, L, c);
      if (H >= 1) begin : g_r0
         assign row0[c] = din[OFF];
      end else begin : g_r0z
         assign row0[c] = 1'b0;
      end
      if (H == 2) begin : g_r1
         assign row1[c] = din[OFF + 1];
      end else begin : g_r1z
         assign row1[c] = 1'b0;
      end
   end

   if (FINAL_ADDER == 0) begin : g_beh
      assign prod = row0 + row1;
   end else begin : g_ripple
      logic [W-1:0] cy;
      assign cy[0] = 1'b0;
      for (genvar k = 0; k < W - 1; k++) begin : g_bit
         wt_fa u_fa (
            .a  (row0[k]),
            .b  (row1[k]),
            .ci (cy[k]),
            .s  (prod[k]),
            .co (cy[k+1])
         );
      end
      assign prod[W-1] = row0[W-1] ^ row1[W-1] ^ cy[W-1];
   end
endmodule

// File: rtl/wt_mult.sv
module wt_mult
   import wt_pkg::*;
#(
   parameter int N           = 8,
   parameter int FINAL_ADDER = 0
) (
   input  logic [N-1:0]   op_a,
   input  logic [N-1:0]   op_b,
   output logic [2*N-1:0] prod
);
   localparam int NL = num_layers(N);

   if (N < 2 || N > 32) begin : g_bad_width
      $error("wt_mult: N must lie in 2..32");
   end
   if (FINAL_ADDER != 0 && FINAL_ADDER != 1) begin : g_bad_adder
      $error("wt_mult: FINAL_ADDER must be 0 or 1");
   end

   for (genvar l = 0; l <= NL; l++) begin : g_lay
      localparam int T = layer_tot(N, l);
      logic [T-1:0] v;
      if (l == 0) begin : g_src
         wt_ppgen #(.N(N)) u_pp (
            .op_a (op_a),
            .op_b (op_b),
            .pp   (v)
         );
      end else begin : g_red
         wt_layer #(.N(N), .L(l - 1)) u_layer (
            .din  (g_lay[l-1].v),
            .dout (v)
         );
      end
   end

   wt_final #(.N(N), .L(NL), .FINAL_ADDER(FINAL_ADDER)) u_final (
      .din  (g_lay[NL].v),
      .prod (prod)
   );
endmodule

module wt_mult_chk #(
   parameter int N = 8
) (
   input logic [N-1:0]   op_a,
   input logic [N-1:0]   op_b,
   input logic [2*N-1:0] prod
);
   localparam int W = 2 * N;

   always_comb begin
      p_exact_r1: assert (prod == W'(op_a) * W'(op_b))
         else $error("R1: product mismatch");
      if (op_a == '0 || op_b == '0)
         p_zero_r2: assert (prod == '0)
            else $error("R2: zero operand gave nonzero product");
      if (op_a == N'(1))
         p_one_r3: assert (prod == W'(op_b))
            else $error("R3: unit operand not transparent");
      if ((&op_a) && (&op_b))
         p_ones_r4: assert (prod[W-1] && prod[0])
            else $error("R4: all-ones square lost a bit");
      p_lsb_r6: assert (prod[0] == (op_a[0] & op_b[0]))
         else $error("R6: bit 0 mismatch");
   end
endmodule

bind wt_mult wt_mult_chk #(.N(N)) u_chk (
   .op_a (op_a),
   .op_b (op_b),
   .prod (prod)
);

// File: tb/wt_mult_test.sv
`timescale 1ns/1ps
module wt_mult_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [7:0]  a8 = '0, b8 = '0;
   logic [15:0] p8;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [7:0]  p4;

   int checks = 0;
   int fails  = 0;
   longint exp_q [$];
   string  req_q [$];

   wt_mult #(.N(8), .FINAL_ADDER(0)) uut (.op_a(a8), .op_b(b8), .prod(p8));
   wt_mult #(.N(4), .FINAL_ADDER(1)) uut4 (.op_a(a4), .op_b(b4), .prod(p4));

   task automatic chk(string req, longint got, longint exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // reference model: expected value queued at drive time, compared next negedge
   task automatic run8(logic [7:0] a, logic [7:0] b, string req);
      @(posedge clk); #1;
      a8 = a; b8 = b;
      exp_q.push_back(longint'(a) * longint'(b));
      req_q.push_back(req);
      @(negedge clk);
      chk(req_q.pop_front(), longint'(p8), exp_q.pop_front());
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 reset-state zero", longint'(p8), 0);

      // R7: exhaustive N=4 through ripple final adder; 15*15 also tags R4
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            @(posedge clk); #1;
            a4 = 4'(i); b4 = 4'(j);
            @(negedge clk);
            chk((i == 15 && j == 15) ? "R4 N=4 all ones" : "R7 N=4 exhaustive",
                longint'(p4), longint'(i * j));
         end
      end

      run8(8'hFF, 8'hFF, "R4 all ones");
      for (int k = 0; k < 6; k++) begin
         r = 8'($urandom);
         run8(8'h00, r, "R2 zero op_a");
         run8(r, 8'h00, "R2 zero op_b");
         run8(8'h01, r, "R3 unit op_a");
         run8(r, 8'h01, "R3 unit op_b");
      end
      run8(8'h01, 8'hFF, "R3 unit times all ones");
      for (int k = 0; k < 8; k++) begin
         r = 8'($urandom);
         run8(8'(1 << k), r, "R5 one-hot op_a");
         run8(r, 8'(1 << k), "R5 one-hot op_b");
         run8(8'(1 << k), 8'hFF, "R5 one-hot times all ones");
      end

      for (int k = 0; k < 3000; k++) begin
         logic [7:0] x, y;
         x = 8'($urandom);
         y = 8'($urandom);
         run8(x, y, "R1 random");
         chk("R6 bit 0", longint'(p8[0]), longint'(x[0] & y[0]));
      end

      finish_run();
   end
endmodule